// File: doc/BRIEF.md
# Frame-Aligned Bit-Clock Counter

This block keeps a running count of the rising edges of an external serial bit clock. The count is split into two cascaded words. The low word advances on every bit-clock edge. The high word advances each time the low word rolls over. All logic runs on a fast system clock. The bit clock and the frame strobe are brought in through synchronizer stages, and their edges are found by sampling.

Software can ask for re-alignment with a sync request. The block then waits for the frame strobe to be low. Next it waits for the strobe to go high, which marks the start of a frame. It counts a fixed number of bit-clock edges into that frame and clears both words on the edge after them. This gives the count a fixed phase to the frames: every value whose low 3 bits (8-bit frames) or low 4 bits (16-bit frames) are zero falls inside a frame transfer. A separate soft clear zeroes the count without re-aligning it.

The count is read through a request/valid port. The port samples the high word, then the low word, and then checks the high word again, so a read never returns two halves taken on opposite sides of a carry. A ready flag shows when the high word can be trusted after an alignment.

Top module: `fsc_counter`

## Requirements
- R1: Each rising edge of `ssp_clk_i` adds one to the low word, modulo 2^LO_W. Without edges, the count holds.
- R2: The high word adds one exactly when an edge takes the low word from all ones to zero. No other counting edge changes the high word.
- R3: After a sync request, alignment waits for `ssp_frame_i` to be seen low and then high. A frame that is already high when the request arrives is skipped, and the next frame is used.
- R4: Bit 0 is the first `ssp_clk_i` rising edge after the frame strobe rises. Alignment arms after edge 2 (8-bit frames) or edge 6 (16-bit frames). The following edge, bit index 2 or 6, loads zero into both words. From then on, the count modulo 8 or 16 is zero at that bit index of every frame.
- R5: The frame width is taken from `wide_frame_i` (0 = 8-bit, 1 = 16-bit) in the cycle the sync request is sampled. Later changes have no effect on that alignment.
- R6: A pulse on `soft_clr_i` clears both words on the next bit-clock edge. Before that edge the count is unchanged. `ready_o` is not affected.
- R7: A one-cycle `rd_req_i` in the idle state produces exactly one single-cycle `rd_valid_o` pulse. The earliest pulse comes 3 clock edges after the request. `rd_count_o` is {high, low}, and its value equals the count at some moment between the request and the valid pulse, even while a carry ripples between the words.
- R8: `ready_o` goes low when a sync request is sampled. It rises together with the first low-word rollover after the alignment zero load.
- R9: After reset the count is zero and `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ssp_clk_i | input | 1 | Serial bit clock, sampled |
| ssp_frame_i | input | 1 | Serial frame strobe, sampled |
| wide_frame_i | input | 1 | Frame width select: 0 = 8 bits, 1 = 16 bits |
| sync_req_i | input | 1 | Start frame alignment (one-cycle pulse) |
| soft_clr_i | input | 1 | Clear count on the next bit-clock edge |
| rd_req_i | input | 1 | Request a coherent read |
| rd_valid_o | output | 1 | Read result valid (one-cycle pulse) |
| rd_count_o | output | LO_W+HI_W | Read result {high, low} |
| ready_o | output | 1 | High word valid since the last alignment |

## Verification
Two situations are hard to reach from the ports.

The first is a torn read, where the carry into the high word lands between the high-word sample and the low-word sample. The bench reaches it with a small low-word width, so the word rolls over every 16 edges, and with back-to-back reads at varying gaps while the bit clock runs freely. Each result is checked against the window of model counts seen during that read.

The second is a sync request made while a frame strobe is already high. The bench times the request into the high phase of bit 0 and expects the zero load in the next frame. It flips the width select right after the request to show that the width was latched.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int ARM_NARROW = 2;
  localparam int ARM_WIDE   = 6;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WLOW, SQ_WHIGH, SQ_CNT, SQ_ARM
  } sq_state_t;

  typedef enum logic [1:0] {
    RD_IDLE, RD_LO, RD_CHK
  } rd_state_t;
endpackage

// File: rtl/fsc_in_sync.sv
module fsc_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ssp_clk_i,
  input  logic ssp_frame_i,
  output logic edge_o,
  output logic frame_o
);
  logic [STAGES-1:0] clk_sh, frm_sh;
  logic clk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sh   <= '0;
      frm_sh   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sh   <= {clk_sh[STAGES-2:0], ssp_clk_i};
      frm_sh   <= {frm_sh[STAGES-2:0], ssp_frame_i};
      clk_prev <= clk_sh[STAGES-1];
    end
  end

  assign edge_o  = clk_sh[STAGES-1] & ~clk_prev;
  assign frame_o = frm_sh[STAGES-1];
endmodule

// File: rtl/fsc_sync_seq.sv
module fsc_sync_seq
  import fsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_req_i,
  input  logic wide_i,
  input  logic frame_i,
  input  logic edge_i,
  output logic zero_o,
  output logic aligned_o
);
  localparam int CW = $clog2(ARM_WIDE + 1);
  localparam logic [CW-1:0] LIM_N = CW'(ARM_NARROW - 1);
  localparam logic [CW-1:0] LIM_W = CW'(ARM_WIDE - 1);

  sq_state_t state;
  logic [CW-1:0] cnt;
  logic wide_q;
  logic [CW-1:0] limit;

  assign limit  = wide_q ? LIM_W : LIM_N;
  assign zero_o = (state == SQ_ARM) && edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      wide_q    <= 1'b0;
      aligned_o <= 1'b0;
    end else if (sync_req_i) begin
      state     <= SQ_WLOW;
      wide_q    <= wide_i;
      cnt       <= '0;
      aligned_o <= 1'b0;
    end else begin
      case (state)
        SQ_WLOW:  if (!frame_i) state <= SQ_WHIGH;
        SQ_WHIGH: if (frame_i) begin
          state <= SQ_CNT;
          cnt   <= '0;
        end
        SQ_CNT: if (edge_i) begin
          if (cnt == limit) state <= SQ_ARM;
          else              cnt   <= cnt + 1'b1;
        end
        SQ_ARM: if (edge_i) begin
          state     <= SQ_IDLE;
          aligned_o <= 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R4: a zero load marks the count as aligned
  p_align_after_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !sync_req_i) |=> aligned_o);
  // R8: a new request drops alignment
  p_req_drops_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_i |=> !aligned_o);
endmodule

// File: rtl/fsc_word.sv
module fsc_word #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  assign carry_o = inc_i & ~clr_i & (&q_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/fsc_cascade.sv
module fsc_cascade #(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic            zero_i,
  input  logic            soft_clr_i,
  input  logic            sync_req_i,
  input  logic            aligned_i,
  output logic [LO_W-1:0] lo_o,
  output logic [HI_W-1:0] hi_o,
  output logic            ready_o
);
  logic clr_pend, clr_now, lo_carry, hi_carry;

  assign clr_now = edge_i & (zero_i | clr_pend);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         clr_pend <= 1'b0;
    else if (soft_clr_i) clr_pend <= 1'b1;
    else if (edge_i)     clr_pend <= 1'b0;
  end

  fsc_word #(.W(LO_W)) u_lo (
    .clk_i, .rst_ni, .inc_i(edge_i), .clr_i(clr_now),
    .q_o(lo_o), .carry_o(lo_carry)
  );

  fsc_word #(.W(HI_W)) u_hi (
    .clk_i, .rst_ni, .inc_i(lo_carry), .clr_i(clr_now),
    .q_o(hi_o), .carry_o(hi_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ready_o <= 1'b0;
    else if (sync_req_i)            ready_o <= 1'b0;
    else if (lo_carry && aligned_i) ready_o <= 1'b1;
  end

  p_lo_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !clr_now) |=> lo_o == LO_W'($past(lo_o) + 1'b1));
  p_lo_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(lo_o));
  p_hi_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !clr_now && (&lo_o)) |=> hi_o == HI_W'($past(hi_o) + 1'b1));
  p_hi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_now && !(edge_i && (&lo_o))) |=> $stable(hi_o));
  p_zero_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_now |=> (lo_o == '0) && (hi_o == '0));
  p_ready_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> lo_o == '0);
endmodule

// File: rtl/fsc_read_port.sv
module fsc_read_port
  import fsc_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_req_i,
  input  logic [LO_W-1:0]      lo_i,
  input  logic [HI_W-1:0]      hi_i,
  output logic                 rd_valid_o,
  output logic [LO_W+HI_W-1:0] rd_count_o
);
  rd_state_t state;
  logic [HI_W-1:0] hi_s;
  logic [LO_W-1:0] lo_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= RD_IDLE;
      hi_s       <= '0;
      lo_s       <= '0;
      rd_valid_o <= 1'b0;
      rd_count_o <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      case (state)
        RD_IDLE: if (rd_req_i) begin
          hi_s  <= hi_i;
          state <= RD_LO;
        end
        RD_LO: begin
          lo_s  <= lo_i;
          state <= RD_CHK;
        end
        RD_CHK: begin
          if (hi_i != hi_s) begin   // carry landed mid-read: retry
            hi_s  <= hi_i;
            state <= RD_LO;
          end else begin
            rd_count_o <= {hi_s, lo_s};
            rd_valid_o <= 1'b1;
            state      <= RD_IDLE;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  p_coherent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_count_o[LO_W+HI_W-1:LO_W] == $past(hi_i));
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/fsc_counter.sv
module fsc_counter #(
  parameter int LO_W        = 16,
  parameter int HI_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ssp_clk_i,
  input  logic                 ssp_frame_i,
  input  logic                 wide_frame_i,
  input  logic                 sync_req_i,
  input  logic                 soft_clr_i,
  input  logic                 rd_req_i,
  output logic                 rd_valid_o,
  output logic [LO_W+HI_W-1:0] rd_count_o,
  output logic                 ready_o
);
  logic edge_s, frame_s, zero_ld, aligned;
  logic [LO_W-1:0] lo_w;
  logic [HI_W-1:0] hi_w;

  fsc_in_sync #(.STAGES(SYNC_STAGES)) u_in (
    .clk_i, .rst_ni, .ssp_clk_i, .ssp_frame_i,
    .edge_o(edge_s), .frame_o(frame_s)
  );

  fsc_sync_seq u_seq (
    .clk_i, .rst_ni, .sync_req_i, .wide_i(wide_frame_i),
    .frame_i(frame_s), .edge_i(edge_s),
    .zero_o(zero_ld), .aligned_o(aligned)
  );

  fsc_cascade #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk_i, .rst_ni, .edge_i(edge_s), .zero_i(zero_ld),
    .soft_clr_i, .sync_req_i, .aligned_i(aligned),
    .lo_o(lo_w), .hi_o(hi_w), .ready_o
  );

  fsc_read_port #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .clk_i, .rst_ni, .rd_req_i, .lo_i(lo_w), .hi_i(hi_w),
    .rd_valid_o, .rd_count_o
  );
endmodule

// File: tb/fsc_counter_bench.sv
module fsc_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 4;
  localparam int HI_W = 12;
  localparam int W    = LO_W + HI_W;
  localparam int LO_MOD = 1 << LO_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ssp_clk = 1'b0, ssp_frame = 1'b0, wide = 1'b0;
  logic sync_req = 1'b0, soft_clr = 1'b0, rd_req = 1'b0;
  logic rd_valid, ready;
  logic [W-1:0] rd_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsc_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_fsc_counter (
    .clk_i(clk), .rst_ni(rst_n), .ssp_clk_i(ssp_clk), .ssp_frame_i(ssp_frame),
    .wide_frame_i(wide), .sync_req_i(sync_req), .soft_clr_i(soft_clr),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_count_o(rd_count),
    .ready_o(ready)
  );

  typedef struct { int lo; int hi; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  int mdl = 0, bit_pos = 0, fw = 8, frame_no = 0, target_frame = -1, arm_n = 2;
  bit aligned_m = 0, rdy_m = 0, clr_m = 0, streaming = 0;
  int last_val = 0;

  // monitor: pop expected item on each result
  always @(negedge clk) begin
    if (rd_valid) begin
      int got, hi_b;
      exp_t e;
      got = int'(rd_count);
      last_val = got;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected valid, got %0d expected none", got);
      end else begin
        e = sb.pop_front();
        hi_b = (e.hi < 0) ? mdl : e.hi;
        if (got < e.lo || got > hi_b) begin
          errors++;
          $display("FAIL %s: got %0d expected %0d..%0d", e.tag, got, e.lo, hi_b);
        end
      end
    end
  end

  task automatic run_bit(input bit do_req, input bit req_wide);
    @(negedge clk); ssp_frame = (bit_pos == 0); ssp_clk = 1'b0;
    @(negedge clk);
    @(negedge clk); ssp_clk = 1'b1;
    if (frame_no == target_frame && bit_pos == arm_n) begin
      mdl = 0; aligned_m = 1; target_frame = -1;
    end else if (clr_m) begin
      mdl = 0;
    end else begin
      if (aligned_m && (mdl % LO_MOD) == LO_MOD - 1) rdy_m = 1;
      mdl = (mdl + 1) % (1 << W);
    end
    clr_m = 0;
    if (do_req) begin
      sync_req = 1'b1; wide = req_wide;
      target_frame = frame_no + 1; arm_n = req_wide ? 6 : 2;
      aligned_m = 0; rdy_m = 0;
    end
    @(negedge clk); sync_req = 1'b0;
    bit_pos++;
    if (bit_pos == fw) begin bit_pos = 0; frame_no++; end
  endtask

  task automatic run_bits(input int n);
    for (int i = 0; i < n; i++) run_bit(1'b0, 1'b0);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_exact(input string tag);
    exp_t e;
    repeat (4) @(negedge clk);
    e.lo = mdl; e.hi = mdl; e.tag = tag;
    sb.push_back(e);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    drain();
  endtask

  task automatic check_ready(input string tag);
    repeat (4) @(negedge clk);
    checks++;
    if (ready !== rdy_m) begin
      errors++;
      $display("FAIL %s: ready got %0b expected %0b", tag, ready, rdy_m);
    end
  endtask

  task automatic check_phase(input string tag, input int m);
    checks++;
    if (last_val % m != 0) begin
      errors++;
      $display("FAIL %s: count %0d mod %0d got %0d expected 0", tag, last_val, m, last_val % m);
    end
  endtask

  task automatic pulse_soft_clr();
    @(negedge clk); soft_clr = 1'b1; clr_m = 1;
    @(negedge clk); soft_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    check_ready("R9 ready after reset");
    read_exact("R9 count after reset");

    // R1: free counting and hold
    run_bits(5);
    read_exact("R1 five edges");
    read_exact("R1 hold without edges");

    // R3/R4: narrow sync requested while frame low
    while (bit_pos != 3) run_bit(1'b0, 1'b0);
    run_bit(1'b1, 1'b0);
    while (target_frame != -1) run_bit(1'b0, 1'b0);
    read_exact("R4 narrow zero load");
    check_phase("R4 narrow phase", 8);
    check_ready("R8 ready low after sync");

    // R2/R8: first rollover after alignment
    run_bits(LO_MOD - 1);
    read_exact("R1 count before rollover");
    check_ready("R8 ready before rollover");
    run_bits(1);
    check_ready("R8 ready at rollover");
    read_exact("R2 high word carry");
    run_bits(8);
    read_exact("R4 narrow phase later frame");
    check_phase("R4 narrow phase repeat", 8);

    // R6: soft clear
    pulse_soft_clr();
    read_exact("R6 count before next edge");
    run_bits(1);
    read_exact("R6 cleared on edge");
    check_ready("R6 ready unaffected");

    // R3/R5: wide sync requested during a high frame strobe; select flipped after
    while (bit_pos != 0) run_bit(1'b0, 1'b0);
    fw = 16;
    run_bit(1'b1, 1'b1);
    wide = 1'b0;
    while (target_frame != -1) run_bit(1'b0, 1'b0);
    read_exact("R3 skip high frame, R5 latched width");
    check_phase("R5 wide phase", 16);
    check_ready("R8 ready cleared by wide sync");
    run_bits(16);
    read_exact("R2 wide carry");
    check_phase("R4 wide phase repeat", 16);
    check_ready("R8 ready after wide rollover");

    // R7: reads racing the carry
    streaming = 1;
    fork
      begin
        run_bits(300);
        streaming = 0;
      end
      begin
        int k = 0;
        while (streaming) begin
          exp_t e;
          e.lo = mdl - 1; e.hi = -1; e.tag = "R7 coherent read";
          sb.push_back(e);
          rd_req = 1'b1;
          @(negedge clk); rd_req = 1'b0;
          while (sb.size() > 0) @(negedge clk);
          repeat (k % 5) @(negedge clk);
          k++;
        end
      end
    join
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule